// File: doc/BRIEF.md
# Presettable Synchronous BCD Decade Counter

This block is one decimal digit of a synchronous counter. It holds a four-bit state in 8421 BCD code and moves on the rising clock edge only. Four control inputs choose the action at each edge, and they take effect in fixed priority. An active-low clear forces the digit to zero. An active-low load copies a four-bit value into the digit. Counting happens when a pair of active-high enables, a parallel enable and a trickle enable, are both high. In every other case the digit holds its value.

A terminal-count flag is high when the digit reads nine and the trickle enable is high. The flag lets several digits be chained into a multi-decade counter. The flag of the lower digit drives the enables of the next digit up, so that digit steps only when the lower one wraps. Codes ten to fifteen can be loaded without change. When the counter runs from one of these codes, it reaches a legal digit within at most two counts.

The state register is an enumerated type with sixteen named states. Legal states S0 to S9 go S0→S1→…→S9→S0 when counting. Illegal states take these count transitions: SX10→SX11, SX11→S6, SX12→SX13, SX13→S4, SX14→SX15, SX15→S2. A priority decoder names the mode for each edge. The modes, from highest to lowest priority, are M_CLEAR (any state → S0), M_LOAD (any state → data input), M_COUNT (count transition above) and M_HOLD (state unchanged).

Top module: `bcd_decade_counter`

## Requirements
- R1: With clear and load high and both enables high, a legal digit 0 to 8 advances by one at the next rising edge, and digit 9 (binary 1001) goes to 0.
- R2: With clear low, the digit is 0 after the next rising edge, whatever the load, data and enable inputs are.
- R3: With clear high and load low, the digit equals the data input after the next rising edge, whatever the enables are. Codes 10 to 15 are stored unchanged.
- R4: With clear and load high, the digit is unchanged after an edge when either enable is low.
- R5: The terminal-count output is 1 exactly when the digit is 9 and the trickle enable is 1. It ignores the parallel enable and the load input, and it follows the trickle enable within the same cycle, with no edge in between.
- R6: The terminal-count output stays 0 in every illegal code 10 to 15, including 11, 13 and 15, whose low bit is set.
- R7: Counting from an illegal code gives 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2, so a legal digit is reached within two counts.
- R8: The digit never changes between rising edges, even when the control or data inputs change in mid-cycle.
- R9: Two digits can be chained by driving both enables of the upper digit from the lower digit's terminal count. The pair then steps through 00 to 99 and returns to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | 4 | Value captured by a load |
| en_p | input | 1 | Parallel count enable, active high |
| en_t | input | 1 | Trickle count enable, active high; also gates the terminal count |
| q | output | 4 | Current digit in 8421 BCD |
| tc | output | 1 | Terminal count: digit is 9 and trickle enable is high |

## Verification
Clear, load and count can all be requested at the same edge, so the priority between them is the main thing to check. The bench first loads every one of the sixteen codes. It then applies each of the sixteen combinations of clear, load and the two enables at the next edge. It compares the result with an arithmetic model in which clear beats load and load beats counting. The same sweep covers the wrap from 9 and the illegal-code steps. It also reads the terminal count a nanosecond after the controls change and the digit just before the edge, to confirm that the flag follows the trickle enable at once and that the digit moves only on the edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W = 4;
    localparam int RADIX   = 10;
    localparam int LAST    = RADIX - 1;

    typedef enum logic [DIGIT_W-1:0] {
        S0, S1, S2, S3, S4, S5, S6, S7, S8, S9,
        SX10, SX11, SX12, SX13, SX14, SX15
    } digit_t;

    typedef enum logic [1:0] {
        M_CLEAR,
        M_LOAD,
        M_COUNT,
        M_HOLD
    } mode_t;
endpackage

// File: rtl/bcd_mode_sel.sv
module bcd_mode_sel
    import bcd_pkg::*;
(
    input  logic  clr_n,
    input  logic  ld_n,
    input  logic  en_p,
    input  logic  en_t,
    output mode_t mode
);
    always_comb begin
        if (!clr_n)
            mode = M_CLEAR;
        else if (!ld_n)
            mode = M_LOAD;
        else if (en_p && en_t)
            mode = M_COUNT;
        else
            mode = M_HOLD;
    end
endmodule

// File: rtl/bcd_step.sv
module bcd_step
    import bcd_pkg::*;
(
    input  digit_t cur,
    output digit_t succ
);
    always_comb begin
        unique case (cur)
            S0:   succ = S1;
            S1:   succ = S2;
            S2:   succ = S3;
            S3:   succ = S4;
            S4:   succ = S5;
            S5:   succ = S6;
            S6:   succ = S7;
            S7:   succ = S8;
            S8:   succ = S9;
            S9:   succ = S0;
            // illegal codes rejoin the sequence within two steps
            SX10: succ = SX11;
            SX11: succ = S6;
            SX12: succ = SX13;
            SX13: succ = S4;
            SX14: succ = SX15;
            SX15: succ = S2;
            default: succ = S0;
        endcase
    end
endmodule

// File: rtl/bcd_tc_dec.sv
module bcd_tc_dec
    import bcd_pkg::*;
(
    input  digit_t cur,
    input  logic   en_t,
    output logic   tc
);
    // full four-bit decode: only the last legal digit qualifies
    always_comb begin
        tc = en_t && (cur == digit_t'(LAST));
    end
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_pkg::*;
(
    input  logic               clk,
    input  logic               clr_n,
    input  logic               ld_n,
    input  logic [DIGIT_W-1:0] din,
    input  logic               en_p,
    input  logic               en_t,
    output logic [DIGIT_W-1:0] q,
    output logic               tc
);
    mode_t  mode;
    digit_t state;
    digit_t succ;
    logic   tc_raw;

    bcd_mode_sel u_mode (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .mode  (mode)
    );

    bcd_step u_step (
        .cur  (state),
        .succ (succ)
    );

    bcd_tc_dec u_tc (
        .cur  (state),
        .en_t (en_t),
        .tc   (tc_raw)
    );

    // state register
    always_ff @(posedge clk) begin
        unique case (mode)
            M_CLEAR: state <= S0;
            M_LOAD:  state <= digit_t'(din);
            M_COUNT: state <= succ;
            M_HOLD:  state <= state;
            default: state <= S0;
        endcase
    end

    // outputs
    always_comb begin
        q  = state;
        tc = tc_raw;
    end
endmodule

// File: rtl/bcd_decade_checker.sv
module bcd_decade_checker (
    input logic       clk,
    input logic       clr_n,
    input logic       ld_n,
    input logic [3:0] din,
    input logic       en_p,
    input logic       en_t,
    input logic [3:0] q,
    input logic       tc
);
    // R2: clear forces zero (the clear is itself the reset here)
    a_r2_clear_zero: assert property (@(posedge clk)
        !clr_n |=> (q == 4'd0));

    // R3: load captures the data input
    a_r3_load_capture: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> (q == $past(din)));

    // R1: legal counting steps by one
    a_r1_step_up: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t && q < 4'd9) |=> (q == $past(q) + 4'd1));

    // R1: nine wraps to zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t && q == 4'd9) |=> (q == 4'd0));

    // R4: a low enable holds the digit
    a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(en_p && en_t)) |=> $stable(q));

    // R7: odd illegal codes land in a legal digit on one count
    a_r7_recover: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t && q > 4'd10 && q[0]) |=> (q < 4'd10));

    // R5/R6: flag only at nine with trickle enable high
    a_r5_tc_only_nine: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> (q == 4'd9 && en_t));

    a_r5_tc_at_nine: assert property (@(posedge clk) disable iff (!clr_n)
        (q == 4'd9 && en_t) |-> tc);
endmodule

bind bcd_decade_counter bcd_decade_checker u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .din   (din),
    .en_p  (en_p),
    .en_t  (en_t),
    .q     (q),
    .tc    (tc)
);

// File: tb/sim_bcd_decade_counter.sv
module sim_bcd_decade_counter;
    logic       clk = 1'b0;
    logic       clr_n, ld_n, en_p, en_t;
    logic [3:0] din;
    logic [3:0] q, q_hi, din_hi;
    logic       tc, tc_hi;
    logic       one;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;
    logic [3:0] exp_q;

    always #10 clk = ~clk;   // 50 MHz

    assign one    = 1'b1;
    assign din_hi = 4'd0;

    bcd_decade_counter u0 (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q), .tc(tc)
    );

    // upper digit of the two-digit chain (R9)
    bcd_decade_counter u1 (
        .clk(clk), .clr_n(clr_n), .ld_n(one), .din(din_hi),
        .en_p(tc), .en_t(tc), .q(q_hi), .tc(tc_hi)
    );

    function automatic logic [3:0] model(input logic [3:0] cur, input logic c,
                                         input logic l, input logic [3:0] d,
                                         input logic p, input logic t);
        if (!c)            return 4'd0;
        if (!l)            return d;
        if (!(p && t))     return cur;
        if (cur < 4'd9)    return cur + 4'd1;
        if (cur == 4'd9)   return 4'd0;
        if (!cur[0])       return cur + 4'd1;
        return 4'd17 - {1'b0, cur};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic cyc(input logic c, input logic l, input logic [3:0] d,
                       input logic p, input logic t);
        string      tg;
        logic [3:0] nq;
        clr_n = c; ld_n = l; din = d; en_p = p; en_t = t;
        nq = model(exp_q, c, l, d, p, t);
        if (!c)                 tg = "R2";
        else if (!l)            tg = "R3";
        else if (!(p && t))     tg = "R4";
        else if (exp_q > 4'd9)  tg = "R7";
        else                    tg = "R1";
        #1;
        chk((exp_q > 4'd9) ? "R6" : "R5", {7'd0, tc}, {7'd0, (t && exp_q == 4'd9)});
        chk("R8", {4'd0, q}, {4'd0, exp_q});
        @(negedge clk);
        chk(tg, {4'd0, q}, {4'd0, nq});
        exp_q = nq;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        clr_n = 1'b0; ld_n = 1'b1; din = 4'd0; en_p = 1'b1; en_t = 1'b1;
        repeat (2) @(negedge clk);
        // reset state: digit zero, flag low (R2)
        chk("R2", {4'd0, q}, 8'd0);
        chk("R5", {7'd0, tc}, 8'd0);
        exp_q = 4'd0;

        // full sweep: every start code against every control pattern
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                cyc(1'b1, 1'b0, 4'(s), 1'b0, 1'b0);
                cyc(c[3], c[2], 4'((s + 5) % 16), c[1], c[0]);
            end
        end

        // mid-cycle flag response to the trickle enable at nine (R5)
        cyc(1'b1, 1'b0, 4'd9, 1'b1, 1'b1);
        ld_n = 1'b1; en_p = 1'b0; en_t = 1'b1;
        #2 chk("R5", {7'd0, tc}, 8'd1);
        en_t = 1'b0;
        #2 chk("R5", {7'd0, tc}, 8'd0);
        en_p = 1'b1;
        #2 chk("R5", {7'd0, tc}, 8'd0);
        @(negedge clk);
        chk("R4", {4'd0, q}, 8'd9);

        // run from each illegal code until legal, at most two counts (R7)
        for (int s = 10; s < 16; s++) begin
            cyc(1'b1, 1'b0, 4'(s), 1'b0, 1'b0);
            cyc(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
            if (exp_q > 4'd9) cyc(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
            chk("R7", {7'd0, (q < 4'd10)}, 8'd1);
        end

        // two-digit chain 00 .. 99 .. 00 (R9)
        cyc(1'b0, 1'b1, 4'd0, 1'b1, 1'b1);
        chk("R9", {q_hi, q}, 8'h00);
        for (int i = 1; i <= 100; i++) begin
            cyc(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
            chk("R9", {q_hi, q}, {4'((i % 100) / 10), 4'(i % 10)});
        end

        finish_up();
    end
endmodule